// File: doc/BRIEF.md
# Capture/Compare Timer-Counter with Split Mode

This block is a 16-bit timer/counter with a small word-wide register interface. It advances either on every system clock (timer mode) or on chosen edges of an external input (counter mode). In timer mode it can compare the count against a register and toggle an output pin on a match. It can also use an edge of the external input either to snapshot the count or to load a new start value into it. One two-bit field does two jobs: it selects the active input edge, and it decides between compare and capture/reload.

A split setting turns the counter into two 8-bit halves. The upper half obeys the timer/counter and edge settings. The lower half is always a compare timer with its own run bit. Overflow, compare, capture and reload events raise sticky flags. Software clears a flag by writing 1 to it. A single interrupt line is gated by an enable bit.

Top module: `cc_timer`

## Requirements
- R1: The control register (address 0) holds, from bit 7 down to bit 0: interrupt enable, output enable, output polarity, low-half run, run, reload select, single-shot, gate enable. All of these bits reset to 0. Bits 15:8 always read 0, and writes to them are ignored.
- R2: With mode register (address 1) bit 0 = 0 (timer) and edge field bits 2:1 = 00, the count at address 2 rises by one on every clock while run is set. When gate enable is set, the count rises only while the synchronized external input is high.
- R3: In compare operation, the capture/compare flag (flag register address 5, bit 1) sets on the clock where the count steps to the compare register (address 4), and an internal output state toggles. The output pin is 0 while output enable is clear; otherwise it is that state XOR the polarity bit.
- R4: When the count steps past all-ones, the overflow flag (flag bit 0) sets. The count becomes the reload/capture register (address 3) if reload select is set, and 0 otherwise. If single-shot is set, the same overflow clears the run bit.
- R5: In timer mode with edge field 01, 10 or 11, the selected edge raises the capture/compare flag. With reload select clear, the edge copies the pre-edge count into address 3. With reload select set, the edge loads the count from address 3.
- R6: In counter mode (mode bit 0 = 1), edge field 01 counts rising edges, 10 counts falling edges and 11 counts both. Edge field 00 leaves the count unchanged.
- R7: The external input passes through a two-flop synchronizer before edge detection. One input transition gives exactly one event, on the third rising clock edge after the input changes.
- R8: With split mode (mode bit 3) set, address 2 reads {high half, low half}. The high half follows the run bit and the mode and edge settings, and compares against compare bits 15:8. The low half counts clocks under the low-half run bit, only ever compares (against compare bits 7:0), and its overflow sets flag bit 2.
- R9: Writing 1 to a flag bit clears it. A set event in the same cycle as the clear wins. The interrupt output is high while the interrupt enable bit is set and any flag is set.
- R10: A write is taken on the clock edge where the write strobe is high. Read data for the address presented before a clock edge appears after that edge. Writing address 2 loads the count directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_in | input | 1 | Asynchronous external input |
| tmr_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The count is driven with free-running clocks, with clocks gated by the external level, and with trains of input pulses. In counter mode each pulse train is replayed under rising, falling, both-edge and no-edge selection, so a result of 3, 3, 6 or 0 shows that each edge code was decoded correctly. Runs that start just below all-ones separate wrap-to-zero, reload-on-overflow and single-shot stop. A single rising edge during a running timer gives a capture value of 2 or a reload result of 0x107, which fixes the synchronizer latency to the exact cycle. In split mode, a nonzero edge field on the low half still produces a compare match, and an 8-bit low overflow leaves the high byte untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int A_CTRL = 0;
  localparam int A_MODE = 1;
  localparam int A_CNT  = 2;
  localparam int A_RLD  = 3;
  localparam int A_CMP  = 4;
  localparam int A_FLG  = 5;

  localparam int FLAG_BITS = 3;

  typedef struct packed {
    logic ien;
    logic oe;
    logic pol;
    logic run_lo;
    logic run;
    logic rl_sel;
    logic one_shot;
    logic gate;
  } ctrl_t;

  typedef struct packed {
    logic       split;
    logic [1:0] edge_sel;
    logic       ctr;
  } mode_t;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];

  // R7
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tmr_lane.sv
module tmr_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         ctr_mode,
  input  logic         cmp_only,
  input  logic [1:0]   sel,
  input  logic         hit,
  input  logic         gate_ok,
  input  logic         reload_sel,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] rld_val,
  output logic [W-1:0] cnt,
  output logic         ovf_ev,
  output logic         match_ev,
  output logic         cap_ev,
  output logic         rl_ev
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic step, trig, wrap, do_rl, cmp_mode;
  logic [W-1:0] nxt;

  always_comb begin
    cmp_mode = cmp_only || (!ctr_mode && sel == 2'b00);
    step     = run && (ctr_mode ? (sel != 2'b00 && hit) : gate_ok);
    trig     = run && !ctr_mode && !cmp_only && sel != 2'b00 && hit;
    wrap     = (cnt == TOP);
    nxt      = wrap ? (reload_sel ? rld_val : {W{1'b0}}) : cnt + 1'b1;
    do_rl    = trig && reload_sel;
    ovf_ev   = !load && step && wrap && !do_rl;
    match_ev = !load && step && !do_rl && cmp_mode && (nxt == cmp_val);
    cap_ev   = !load && trig && !reload_sel;
    rl_ev    = !load && do_rl;
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (do_rl) cnt <= rld_val;
    else if (step)  cnt <= nxt;
  end

  // R6
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctr_mode && !cmp_only && sel == 2'b00 && !load) |=> cnt == $past(cnt));

  // R4
  wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> cnt == $past(reload_sel ? rld_val : {W{1'b0}}));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3,
  localparam int HW = CW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] cnt_rd,
  input  logic          ovf_main,
  input  logic          ovf_lo,
  input  logic          cc_ev,
  input  logic          tog_ev,
  input  logic          cap_full,
  input  logic [CW-1:0] cap_full_val,
  input  logic          cap_hi,
  input  logic [HW-1:0] cap_hi_val,
  output ctrl_t         ctrl,
  output mode_t         mode,
  output logic [CW-1:0] cmp_r,
  output logic [CW-1:0] rld_r,
  output logic [CW-1:0] rdata,
  output logic          irq,
  output logic          out_pin
);
  logic [FLAG_BITS-1:0] flags, set_vec, clr_vec;
  logic                 tog;
  logic [CW-1:0]        rd_n;

  always_comb begin
    set_vec = {ovf_lo, cc_ev, ovf_main};
    clr_vec = (we && addr == AW'(A_FLG)) ? wdata[FLAG_BITS-1:0] : '0;
    rd_n = '0;
    case (addr)
      AW'(A_CTRL): rd_n[7:0] = ctrl;
      AW'(A_MODE): rd_n[3:0] = mode;
      AW'(A_CNT):  rd_n = cnt_rd;
      AW'(A_RLD):  rd_n = rld_r;
      AW'(A_CMP):  rd_n = cmp_r;
      AW'(A_FLG):  rd_n[FLAG_BITS-1:0] = flags;
      default:     rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      mode  <= '0;
      cmp_r <= '0;
      rld_r <= '0;
      flags <= '0;
      tog   <= 1'b0;
      rdata <= '0;
    end else begin
      if (we) begin
        case (addr)
          AW'(A_CTRL): ctrl  <= ctrl_t'(wdata[7:0]);
          AW'(A_MODE): mode  <= mode_t'(wdata[3:0]);
          AW'(A_RLD):  rld_r <= wdata;
          AW'(A_CMP):  cmp_r <= wdata;
          default: ;
        endcase
      end
      if (cap_full) rld_r <= cap_full_val;
      if (cap_hi)   rld_r[CW-1:HW] <= cap_hi_val;
      if (ctrl.one_shot && ovf_main) ctrl.run    <= 1'b0;
      if (ctrl.one_shot && ovf_lo)   ctrl.run_lo <= 1'b0;
      flags <= (flags & ~clr_vec) | set_vec;
      if (tog_ev) tog <= ~tog;
      rdata <= rd_n;
    end
  end

  assign irq     = ctrl.ien && (flags != '0);
  assign out_pin = ctrl.oe && (tog ^ ctrl.pol);

  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == AW'(A_CTRL)) |=> rdata[CW-1:8] == '0);

  // R9
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_main |=> flags[0]);

  // R9
  cc_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cc_ev |=> flags[1]);

  // R3
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    tog_ev |=> tog != $past(tog));

  // R4
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.one_shot && ovf_main) |=> !ctrl.run);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import tmr_pkg::*;
#(
  parameter int CW          = 16,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          ext_in,
  output logic          tmr_out,
  output logic          irq
);
  localparam int HW = CW / 2;

  ctrl_t         ctrl;
  mode_t         mode;
  logic [CW-1:0] cmp_r, rld_r, cnt_rd, full_cnt;
  logic [HW-1:0] hi_cnt, lo_cnt;
  logic          lvl, rise, fall, hit, gate_ok, load;
  logic          f_ovf, f_match, f_cap, f_rl;
  logic          h_ovf, h_match, h_cap, h_rl;
  logic          l_ovf, l_match, l_cap, l_rl;

  tmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(ext_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  always_comb begin
    case (mode.edge_sel)
      2'b01:   hit = rise;
      2'b10:   hit = fall;
      2'b11:   hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end

  assign gate_ok = !ctrl.gate || lvl;
  assign load    = bus_we && bus_addr == AW'(A_CNT);

  tmr_lane #(.W(CW)) u_full (
    .clk(clk), .rst(rst), .load(load), .load_val(bus_wdata),
    .run(ctrl.run && !mode.split), .ctr_mode(mode.ctr), .cmp_only(1'b0),
    .sel(mode.edge_sel), .hit(hit), .gate_ok(gate_ok),
    .reload_sel(ctrl.rl_sel), .cmp_val(cmp_r), .rld_val(rld_r),
    .cnt(full_cnt), .ovf_ev(f_ovf), .match_ev(f_match),
    .cap_ev(f_cap), .rl_ev(f_rl)
  );

  tmr_lane #(.W(HW)) u_hi (
    .clk(clk), .rst(rst), .load(load), .load_val(bus_wdata[CW-1:HW]),
    .run(ctrl.run && mode.split), .ctr_mode(mode.ctr), .cmp_only(1'b0),
    .sel(mode.edge_sel), .hit(hit), .gate_ok(gate_ok),
    .reload_sel(ctrl.rl_sel), .cmp_val(cmp_r[CW-1:HW]),
    .rld_val(rld_r[CW-1:HW]),
    .cnt(hi_cnt), .ovf_ev(h_ovf), .match_ev(h_match),
    .cap_ev(h_cap), .rl_ev(h_rl)
  );

  tmr_lane #(.W(HW)) u_lo (
    .clk(clk), .rst(rst), .load(load), .load_val(bus_wdata[HW-1:0]),
    .run(ctrl.run_lo && mode.split), .ctr_mode(1'b0), .cmp_only(1'b1),
    .sel(mode.edge_sel), .hit(hit), .gate_ok(gate_ok),
    .reload_sel(ctrl.rl_sel), .cmp_val(cmp_r[HW-1:0]),
    .rld_val(rld_r[HW-1:0]),
    .cnt(lo_cnt), .ovf_ev(l_ovf), .match_ev(l_match),
    .cap_ev(l_cap), .rl_ev(l_rl)
  );

  assign cnt_rd = mode.split ? {hi_cnt, lo_cnt} : full_cnt;

  tmr_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cnt_rd(cnt_rd),
    .ovf_main(f_ovf | h_ovf),
    .ovf_lo(l_ovf),
    .cc_ev(f_match | f_cap | f_rl | h_match | h_cap | h_rl
           | l_match | l_cap | l_rl),
    .tog_ev(f_match | h_match | l_match),
    .cap_full(f_cap), .cap_full_val(full_cnt),
    .cap_hi(h_cap), .cap_hi_val(hi_cnt),
    .ctrl(ctrl), .mode(mode), .cmp_r(cmp_r), .rld_r(rld_r),
    .rdata(bus_rdata), .irq(irq), .out_pin(tmr_out)
  );

  // R8
  lo_compare_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_cap || l_rl));
endmodule

// File: tb/cc_timer_test.sv
`timescale 1ns/1ps
module cc_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_in = 1'b0;
  logic        tmr_out, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  logic rd_req = 1'b0;
  logic rd_req_d = 1'b0;

  always #5 clk = ~clk;

  cc_timer uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
    .tmr_out(tmr_out), .irq(irq)
  );

  always @(posedge clk) rd_req_d <= rd_req;

  // monitor: pops expected items and compares against read data
  always @(negedge clk) begin
    if (rd_req_d && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    rd_req = 1'b1;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pin(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, e);
    end
  endtask

  task automatic pulse();
    ext_in = 1'b1; idle(4);
    ext_in = 1'b0; idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 16'h0000, "R1 ctrl reset");
    rd(1, 16'h0000, "R10 mode reset");
    rd(2, 16'h0000, "R10 count reset");
    rd(5, 16'h0000, "R9 flags reset");
    pin(irq, 1'b0, "R9 irq reset");
    pin(tmr_out, 1'b0, "R3 out reset");

    // R1 reserved bits and field storage
    wr(0, 16'hFF00);
    rd(0, 16'h0000, "R1 reserved ignored");
    wr(0, 16'hFFA5);
    rd(0, 16'h00A5, "R1 ctrl bits");
    wr(0, 16'h0000);

    // R2 free-running timer
    wr(4, 16'h8000); wr(1, 16'h0000); wr(2, 16'h0000);
    wr(0, 16'h0008); idle(8); wr(0, 16'h0000);
    rd(2, 16'd10, "R2 timer count");

    // R3 compare match, output and irq
    wr(4, 16'd5); wr(2, 16'h0000); wr(5, 16'h0007);
    wr(0, 16'h00C8); idle(18); wr(0, 16'h00C0);
    rd(2, 16'd20, "R3 count past match");
    rd(5, 16'h0002, "R3 cc flag");
    pin(tmr_out, 1'b1, "R3 out toggled");
    pin(irq, 1'b1, "R9 irq raised");
    wr(0, 16'h00E0);
    pin(tmr_out, 1'b0, "R3 polarity");
    wr(5, 16'h0002);
    rd(5, 16'h0000, "R9 w1c");
    pin(irq, 1'b0, "R9 irq cleared");
    wr(0, 16'h0000);

    // R4 overflow wrap with simultaneous match at zero
    wr(4, 16'h0000); wr(2, 16'hFFFE); wr(5, 16'h0007);
    wr(0, 16'h0008); idle(1); wr(0, 16'h0000);
    rd(2, 16'h0001, "R4 wrap to zero");
    rd(5, 16'h0003, "R4 ovf and match flags");
    wr(5, 16'h0001);
    rd(5, 16'h0002, "R9 partial clear");

    // R4 reload on overflow
    wr(4, 16'h8000); wr(3, 16'h1000); wr(2, 16'hFFFE); wr(5, 16'h0007);
    wr(0, 16'h000C); idle(1); wr(0, 16'h0000);
    rd(2, 16'h1001, "R4 reload on ovf");
    rd(5, 16'h0001, "R4 ovf flag");

    // R4 single-shot stops run
    wr(2, 16'hFFFE);
    wr(0, 16'h000A); idle(4);
    rd(0, 16'h0002, "R4 single-shot clears run");
    rd(2, 16'h0000, "R4 single-shot count");
    wr(0, 16'h0000);

    // R2 gate
    wr(2, 16'h0000);
    wr(0, 16'h0009); idle(8); wr(0, 16'h0000);
    rd(2, 16'h0000, "R2 gate low holds");
    ext_in = 1'b1; idle(4);
    wr(0, 16'h0009); idle(8); wr(0, 16'h0000);
    rd(2, 16'd10, "R2 gate high counts");
    ext_in = 1'b0; idle(4);

    // R5 R7 capture on rising edge
    wr(1, 16'h0002); wr(2, 16'h0000); wr(3, 16'h0000); wr(5, 16'h0007);
    wr(0, 16'h0008); ext_in = 1'b1; idle(8); wr(0, 16'h0000);
    rd(3, 16'd2, "R7 capture latency");
    rd(2, 16'd10, "R5 count after capture");
    rd(5, 16'h0002, "R5 capture flag");
    ext_in = 1'b0; idle(4);

    // R5 reload on rising edge
    wr(3, 16'h0100); wr(2, 16'h0000);
    wr(0, 16'h000C); ext_in = 1'b1; idle(8); wr(0, 16'h0000);
    rd(2, 16'h0107, "R5 reload on edge");
    ext_in = 1'b0; idle(4);

    // R6 counter mode edge selection
    wr(1, 16'h0003); wr(2, 16'h0000); wr(0, 16'h0008);
    pulse(); pulse(); pulse(); wr(0, 16'h0000);
    rd(2, 16'd3, "R6 rising edges");
    wr(1, 16'h0005); wr(2, 16'h0000); wr(0, 16'h0008);
    pulse(); pulse(); pulse(); wr(0, 16'h0000);
    rd(2, 16'd3, "R6 falling edges");
    wr(1, 16'h0007); wr(2, 16'h0000); wr(0, 16'h0008);
    pulse(); pulse(); pulse(); wr(0, 16'h0000);
    rd(2, 16'd6, "R6 both edges");
    wr(1, 16'h0001); wr(2, 16'h0000); wr(0, 16'h0008);
    pulse(); pulse(); wr(0, 16'h0000);
    rd(2, 16'd0, "R6 no edge holds");

    // R8 split: low half compares even with edge field set
    wr(1, 16'h000A); wr(4, 16'h0003); wr(2, 16'h0000); wr(5, 16'h0007);
    wr(0, 16'h0010); idle(8); wr(0, 16'h0000);
    rd(2, 16'h000A, "R8 low half count");
    rd(5, 16'h0002, "R8 low half compare");

    // R8 split low overflow
    wr(4, 16'h0080); wr(2, 16'h00FE); wr(5, 16'h0007);
    wr(0, 16'h0010); idle(1); wr(0, 16'h0000);
    rd(2, 16'h0001, "R8 low wrap keeps high");
    rd(5, 16'h0004, "R8 low ovf flag");

    // R8 split high half in counter mode
    wr(1, 16'h000B); wr(2, 16'h0000); wr(0, 16'h0008);
    pulse(); pulse(); wr(0, 16'h0000);
    rd(2, 16'h0200, "R8 high half counts edges");

    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule